// File: doc/BRIEF.md
# Shared-Pin Bus Request/Grant Arbiter

This block decides which of several conduit hosts may drive a set of shared external pins, such as the address and data lines of a memory device. Each host raises a request line and watches its own grant line. The arbiter hands the pins to one host at a time and supplies the binary index of the owner, which steers the multiplexer in front of the shared pins. It also gates the shared output-enable so that only the owner can turn the pads around.

Whether a request is high means one of two things, depending on the host's grant. Without grant, a high request asks for the bus now. With grant held, a high request asks to keep the bus for the next cycle. A host therefore drops its request in the final cycle of its access. Grant then falls one cycle later. If another host is already waiting at that point, the bus passes to it with no idle cycle. When several hosts wait, a rotating pointer chooses among them, starting at the host after the last owner.

When pin sharing is switched off through a parameter, host 0 owns the pins permanently and every request is ignored.

Top module: `shared_pin_arbiter`

## Requirements
- R1: While reset (rstN low) is applied, every bit of hostGrant is 0, ownerSel is 0 and pinOe is 0.
- R2: A grant bit rises only if that host's request was high in the cycle before. A host that requests while the bus is free has its grant high in the next cycle.
- R3: While the owner keeps its request high, its grant stays high and no other grant bit rises, whatever the other hosts request.
- R4: When the owner drops its request in cycle t, its grant is still high in cycle t and is low from cycle t+1 on.
- R5: At most one bit of hostGrant is high in any cycle.
- R6: When several hosts request at a grant point, the first requesting host at or after the pointer wins. Search order is ascending index and wraps around. After each grant the pointer moves to the winner's index plus one, modulo NUM_HOSTS. Reset sets the pointer to 0.
- R7: If another host is requesting in the cycle where the owner drops its request, that host holds the grant in the very next cycle, with no idle cycle between owners.
- R8: While any grant is high, ownerSel equals the binary index of the granted host and pinOe equals bit ownerSel of hostOeReq. With no grant, pinOe is 0.
- R9: With SHARE_EN = 0, from the first cycle after reset hostGrant is 1 on bit 0 only, ownerSel is 0 and pinOe equals hostOeReq[0], for any value of hostReq.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostReq | input | NUM_HOSTS | Per-host bus request |
| hostOeReq | input | NUM_HOSTS | Per-host wish to drive the shared pins |
| hostGrant | output | NUM_HOSTS | Per-host grant, at most one high |
| ownerSel | output | $clog2(NUM_HOSTS) | Binary index of the current owner, for the pin multiplexer |
| pinOe | output | 1 | Output-enable for the shared pins, on behalf of the owner only |

## Verification
The release of the bus by its owner and the grant to a waiting host can fall on the same clock edge. The bench provokes this in two ways. In one, a competitor keeps its request high while the owner drops its own. In the other, all hosts request at once and each drops its request in its first granted cycle, so one edge after another carries both a release and a fresh grant. A run is judged correct when each new owner's grant appears in the cycle right after the old owner's final cycle. The winners must also follow the rotating order worked out from the pointer, and two grants must never be high together.

// File: rtl/arb_pkg.sv
package arb_pkg;
  // strobes from the control to the datapath
  typedef struct packed {
    logic grantNew;   // load the round-robin winner as new owner
    logic dropOwner;  // owner released the bus, clear its grant
  } arbStrobe_t;
endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       anyReq,
  input  logic       ownerReq,
  output arbStrobe_t strobe
);
  logic busy;

  always_comb begin
    strobe.dropOwner = busy & ~ownerReq;
    strobe.grantNew  = (~busy | ~ownerReq) & anyReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busy <= 1'b0;
    else       busy <= strobe.grantNew | (busy & ownerReq);
  end

  // R7: a release with a waiting host leaves the bus owned next cycle
  assert_handover_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !ownerReq && anyReq) |=> busy);
endmodule

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
#(
  parameter int NUM_HOSTS = 4,
  parameter int SEL_W     = $clog2(NUM_HOSTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_HOSTS-1:0] hostReq,
  input  logic [NUM_HOSTS-1:0] hostOeReq,
  input  arbStrobe_t           strobe,
  output logic                 anyReq,
  output logic                 ownerReq,
  output logic [NUM_HOSTS-1:0] grantVec,
  output logic [SEL_W-1:0]     ownerIdx,
  output logic                 pinOe
);
  localparam logic [SEL_W-1:0] LAST_IDX = SEL_W'(NUM_HOSTS - 1);

  logic [SEL_W-1:0] rrPtr;
  logic [SEL_W-1:0] winner;
  logic [SEL_W-1:0] nextPtr;
  logic             found;

  // first requester at or after the pointer, wrapping
  always_comb begin
    winner = '0;
    found  = 1'b0;
    for (int i = 0; i < NUM_HOSTS; i++) begin
      int idx;
      idx = int'(rrPtr) + i;
      if (idx >= NUM_HOSTS) idx = idx - NUM_HOSTS;
      if (!found && hostReq[idx]) begin
        found  = 1'b1;
        winner = SEL_W'(idx);
      end
    end
  end

  assign nextPtr  = (winner == LAST_IDX) ? '0 : winner + 1'b1;
  assign anyReq   = |hostReq;
  assign ownerReq = hostReq[ownerIdx];
  assign pinOe    = (|grantVec) & hostOeReq[ownerIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantVec <= '0;
      ownerIdx <= '0;
      rrPtr    <= '0;
    end else if (strobe.grantNew) begin
      grantVec <= NUM_HOSTS'(1) << winner;
      ownerIdx <= winner;
      rrPtr    <= nextPtr;
    end else if (strobe.dropOwner) begin
      grantVec <= '0;
    end
  end

  assert_single_owner_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantVec));

  assert_hold_while_req_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((|grantVec) && ownerReq) |=> $stable(grantVec));

  for (genvar h = 0; h < NUM_HOSTS; h++) begin : g_hostChk
    assert_grant_needs_req_R2: assert property (@(posedge clk) disable iff (!rstN)
      $rose(grantVec[h]) |-> $past(hostReq[h]));
    assert_release_after_drop_R4: assert property (@(posedge clk) disable iff (!rstN)
      $fell(grantVec[h]) |-> !$past(hostReq[h]));
  end
endmodule

// File: rtl/shared_pin_arbiter.sv
module shared_pin_arbiter
  import arb_pkg::*;
#(
  parameter int NUM_HOSTS = 4,
  parameter bit SHARE_EN  = 1'b1,
  localparam int SEL_W    = $clog2(NUM_HOSTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_HOSTS-1:0] hostReq,
  input  logic [NUM_HOSTS-1:0] hostOeReq,
  output logic [NUM_HOSTS-1:0] hostGrant,
  output logic [SEL_W-1:0]     ownerSel,
  output logic                 pinOe
);
  logic [NUM_HOSTS-1:0] reqEff;
  logic                 anyReq;
  logic                 ownerReq;
  arbStrobe_t           strobe;

  // without sharing, host 0 requests forever and never lets go
  if (SHARE_EN) begin : g_shared
    assign reqEff = hostReq;
  end else begin : g_fixed
    assign reqEff = NUM_HOSTS'(1) | (hostReq & '0);
  end

  arb_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .anyReq   (anyReq),
    .ownerReq (ownerReq),
    .strobe   (strobe)
  );

  arb_datapath #(.NUM_HOSTS(NUM_HOSTS), .SEL_W(SEL_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .hostReq   (reqEff),
    .hostOeReq (hostOeReq),
    .strobe    (strobe),
    .anyReq    (anyReq),
    .ownerReq  (ownerReq),
    .grantVec  (hostGrant),
    .ownerIdx  (ownerSel),
    .pinOe     (pinOe)
  );

  assert_oe_needs_owner_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(|hostGrant) |-> !pinOe);
endmodule

// File: tb/shared_pin_arbiter_tb.sv
module shared_pin_arbiter_tb;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] req = '0;
  logic [N-1:0] oe = '0;
  logic [N-1:0] grant, grantFix;
  logic [1:0]   sel, selFix;
  logic         pinOe, pinOeFix;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  shared_pin_arbiter #(.NUM_HOSTS(N), .SHARE_EN(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .hostReq(req), .hostOeReq(oe),
    .hostGrant(grant), .ownerSel(sel), .pinOe(pinOe));

  shared_pin_arbiter #(.NUM_HOSTS(N), .SHARE_EN(1'b0)) u_dutFixed (
    .clk(clk), .rstN(rstN), .hostReq(req), .hostOeReq(oe),
    .hostGrant(grantFix), .ownerSel(selFix), .pinOe(pinOeFix));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic testReset();
    #5;
    chk("R1 grant", 32'(grant), 0);
    chk("R1 sel", 32'(sel), 0);
    chk("R1 pinOe", 32'(pinOe), 0);
    chk("R1 fixed grant", 32'(grantFix), 0);
    step(); step();
    rstN = 1'b1;
  endtask

  task automatic testSingle();
    req = 4'b0010;
    step();
    chk("R2 grant host1", 32'(grant), 32'b0010);
    chk("R8 sel host1", 32'(sel), 1);
    chk("R9 fixed ignores req", 32'(grantFix), 32'b0001);
    req = 4'b0000;
    #1 chk("R4 grant kept in final cycle", 32'(grant), 32'b0010);
    step();
    chk("R4 grant released", 32'(grant), 0);
  endtask

  task automatic testHold();
    req = 4'b0101;  // pointer is 2
    step();
    chk("R6 pointer picks host2", 32'(grant), 32'b0100);
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R3 owner holds against host0", 32'(grant), 32'b0100);
    end
    req = 4'b0001;
    #1 chk("R4 final cycle still granted", 32'(grant), 32'b0100);
    step();
    chk("R7 handover without gap", 32'(grant), 32'b0001);
    chk("R8 sel host0", 32'(sel), 0);
    req = 4'b0000;
    step();
    chk("R4 idle after host0", 32'(grant), 0);
  endtask

  task automatic testRotate();
    int order[4] = '{1, 2, 3, 0};  // pointer is 1
    req = 4'b1111;
    foreach (order[k]) begin
      step();
      chk("R6 rotation", 32'(grant), 32'(1) << order[k]);
      chk("R5 single grant", 32'($countones(grant)), 1);
      req[order[k]] = 1'b0;
    end
    step();
    chk("R4 all released", 32'(grant), 0);
  endtask

  task automatic testOe();
    req = 4'b1000;
    step();
    chk("R2 host3 granted", 32'(grant), 32'b1000);
    oe = 4'b1000;
    #1 chk("R8 owner drives oe", 32'(pinOe), 1);
    oe = 4'b0111;
    #1 chk("R8 non-owner oe blocked", 32'(pinOe), 0);
    chk("R9 fixed oe follows host0", 32'(pinOeFix), 1);
    req = 4'b0000;
    oe = 4'b1111;
    step();
    #1 chk("R8 no owner no oe", 32'(pinOe), 0);
    chk("R9 fixed still owns", 32'(grantFix), 32'b0001);
    chk("R9 fixed sel", 32'(selFix), 0);
    oe = 4'b0000;
  endtask

  initial begin
    testReset();
    step();
    testSingle();
    testHold();
    testRotate();
    testOe();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule